// File: doc/BRIEF.md
# Bus Controller Instruction Sequencer

This block steps through a program of two-word instructions stored in a shared 16-bit word-addressed RAM on behalf of a serial-bus controller. Each instruction is an opcode word followed by a parameter word. The sequencer holds an instruction pointer, a four-entry return stack and eight general purpose condition flags. For every instruction it tests a condition code against the flags. If the test passes it performs a jump, call, return, flag update, immediate memory write, write-pointer change, decrement-and-skip, interrupt request or halt. If the test fails it skips the instruction.

Sending a message is handled elsewhere. An execute instruction raises a request carrying its parameter as a control-block pointer, waits for a done pulse and records the good/bad result in flag 0. The execute-and-flip variant also rewrites its own parameter word, so alternate passes use two control blocks that sit 16 words apart. The decrement-and-skip instruction works on any RAM word, which lets a program build counted loops.

The host loads a program into RAM, places its first address on `start_addr` and pulses `start`. It then watches `busy`, `halted` and `stack_err`.

Top module: `bcseq_top`

## Requirements
- R1: After reset `busy`, `halted`, `stack_err`, `msg_req`, `irq_valid`, `mem_rd_en` and `mem_wr_en` are all 0, all flags are clear, and the write pointer is 0x0050.
- R2: A `start` pulse while idle or halted loads the pointer from `start_addr`, clears the return stack and `stack_err`, and fetches the opcode word at the pointer and then the parameter word at pointer+1. RAM read data is valid one cycle after `mem_rd_en`. A `start` pulse while busy is ignored.
- R3: The opcode is held in bits [4:0] of the opcode word and the condition code in bits [12:8]. Opcodes are: execute 0x01, jump 0x02, call 0x03, return 0x04, interrupt 0x06, halt 0x07, flag 0x0C, execute-and-flip 0x15, set write pointer 0x1B, write immediate 0x1C, decrement-and-skip 0x1D. Unknown opcodes do nothing. Sequential flow adds 2 to the pointer. Jump and call targets are the absolute parameter value.
- R4: Condition code 0 is always true. Code 1 is never true. Codes 16+n are true when flag n is set, and codes 8+n are true when flag n is clear (n = 0..7). All other codes are false. A false condition skips the instruction with no side effect.
- R5: Execute drives `msg_req` high with `msg_ptr` equal to the parameter, held stable until `msg_done`. Flag 0 then takes the value of `msg_bad`.
- R6: Call pushes pointer+2 and return pops it. The stack holds 4 entries. A call with 4 entries stored, or a return with none stored, halts the sequencer and sets `stack_err`.
- R7: When its condition is true, execute-and-flip runs the message and then writes its parameter XOR 0x0010 back into its own parameter word (pointer+1).
- R8: Decrement-and-skip writes (RAM[param] − 1) back to RAM[param]. If the result is zero the next instruction is skipped (pointer+4), otherwise the pointer advances by 2.
- R9: Write immediate stores the parameter at the write pointer. Set write pointer loads the parameter only if it is at least 0x0050. Smaller values leave the pointer unchanged.
- R10: In the flag instruction, parameter bit n sets flag n and bit n+8 clears flag n. When both bits are set, flag n toggles.
- R11: Interrupt produces a single-cycle `irq_valid` with `irq_code` equal to parameter bits [3:0]. Halt stops the sequencer with `halted`=1, `busy`=0, and no further RAM writes or message requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin execution at `start_addr` |
| start_addr | input | 16 | First instruction address |
| mem_rd_en | output | 1 | RAM read strobe |
| mem_wr_en | output | 1 | RAM write strobe |
| mem_addr | output | 16 | RAM word address |
| mem_wdata | output | 16 | RAM write data |
| mem_rdata | input | 16 | RAM read data, one cycle after the read strobe |
| msg_req | output | 1 | Message transfer request |
| msg_ptr | output | 16 | Control-block pointer for the request |
| msg_done | input | 1 | Message finished pulse |
| msg_bad | input | 1 | Message result is bad, valid with `msg_done` |
| irq_valid | output | 1 | Interrupt request pulse |
| irq_code | output | 4 | Interrupt pattern |
| busy | output | 1 | Sequencer running |
| halted | output | 1 | Sequencer stopped by halt or stack error |
| stack_err | output | 1 | Return stack overflow or underflow |

## Verification
On every cycle the assertions check four things. The message request and its pointer stay stable until done. A stack error always comes with the halted state. The stack is never pushed when full or popped when empty. A halted sequencer issues no writes or requests. The first fetch after start must also use the start address. Other behaviour shows only in the bench scenarios, which run small programs in a RAM model and inspect the resulting memory and message log. These scenarios cover the condition truth table across all 32 codes, the loop counts built from decrement-and-skip, nesting depth against the stack limit, the alternating pointer of execute-and-flip, and the rejection of low write-pointer values.

// File: rtl/bcseq_pkg.sv
package bcseq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_FETCH,
        ST_OPW,
        ST_PARW,
        ST_EXEC,
        ST_MSG,
        ST_FLIP,
        ST_DSZR,
        ST_DSZW,
        ST_HALT
    } seq_state_e;

    localparam int OPC_W    = 5;
    localparam int COND_W   = 5;
    localparam int OPC_LSB  = 0;
    localparam int COND_LSB = 8;

    localparam logic [OPC_W-1:0] OP_EXEC  = 5'h01;
    localparam logic [OPC_W-1:0] OP_JUMP  = 5'h02;
    localparam logic [OPC_W-1:0] OP_CALL  = 5'h03;
    localparam logic [OPC_W-1:0] OP_RET   = 5'h04;
    localparam logic [OPC_W-1:0] OP_IRQ   = 5'h06;
    localparam logic [OPC_W-1:0] OP_HALT  = 5'h07;
    localparam logic [OPC_W-1:0] OP_FLAG  = 5'h0C;
    localparam logic [OPC_W-1:0] OP_XFLIP = 5'h15;
    localparam logic [OPC_W-1:0] OP_SETWP = 5'h1B;
    localparam logic [OPC_W-1:0] OP_WIMM  = 5'h1C;
    localparam logic [OPC_W-1:0] OP_DSKIP = 5'h1D;

endpackage

// File: rtl/bcseq_cond.sv
module bcseq_cond #(
    parameter int NFLAGS = 8
) (
    input  logic [bcseq_pkg::COND_W-1:0] code,
    input  logic [NFLAGS-1:0]            flags,
    output logic                         pass
);
    logic [2:0] sel;

    always_comb begin
        sel  = code[2:0];
        pass = 1'b0;
        if (code == '0) begin
            pass = 1'b1;
        end else if (code[4:3] == 2'b10 && int'(sel) < NFLAGS) begin
            pass = flags[sel];
        end else if (code[4:3] == 2'b01 && int'(sel) < NFLAGS) begin
            pass = !flags[sel];
        end
    end
endmodule

// File: rtl/bcseq_stack.sv
module bcseq_stack #(
    parameter int DEPTH = 4,
    parameter int W     = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] push_data,
    output logic [W-1:0] top_data,
    output logic         full,
    output logic         empty
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int IW = $clog2(DEPTH);

    logic [DEPTH-1:0][W-1:0] ent_d, ent_q;
    logic [CW-1:0]           cnt_d, cnt_q;
    logic [CW-1:0]           top_idx;

    always_comb begin
        full     = (cnt_q == CW'(DEPTH));
        empty    = (cnt_q == '0);
        top_idx  = cnt_q - CW'(1);
        top_data = ent_q[top_idx[IW-1:0]];
        ent_d    = ent_q;
        cnt_d    = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (push && !full) begin
            ent_d[cnt_q[IW-1:0]] = push_data;
            cnt_d = cnt_q + CW'(1);
        end else if (pop && !empty) begin
            cnt_d = cnt_q - CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ent_q <= '0;
            cnt_q <= '0;
        end else begin
            ent_q <= ent_d;
            cnt_q <= cnt_d;
        end
    end

    assert_push_not_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    assert_pop_not_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
    assert_count_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(DEPTH));
endmodule

// File: rtl/bcseq_top.sv
module bcseq_top #(
    parameter int          AW          = 16,
    parameter int          DW          = 16,
    parameter int          NFLAGS      = 8,
    parameter int          STACK_DEPTH = 4,
    parameter logic [15:0] WPTR_RESET  = 16'h0050,
    parameter logic [15:0] WPTR_MIN    = 16'h0050,
    parameter logic [15:0] FLIP_MASK   = 16'h0010
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] start_addr,
    output logic          mem_rd_en,
    output logic          mem_wr_en,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic          msg_req,
    output logic [DW-1:0] msg_ptr,
    input  logic          msg_done,
    input  logic          msg_bad,
    output logic          irq_valid,
    output logic [3:0]    irq_code,
    output logic          busy,
    output logic          halted,
    output logic          stack_err
);
    import bcseq_pkg::*;

    localparam int COND_MSB = COND_LSB + COND_W - 1;
    localparam int OPC_MSB  = OPC_LSB + OPC_W - 1;

    typedef struct packed {
        seq_state_e        state;
        logic [AW-1:0]     ip;
        logic [OPC_W-1:0]  opc;
        logic [COND_W-1:0] cond;
        logic [DW-1:0]     par;
        logic [NFLAGS-1:0] flags;
        logic [AW-1:0]     wptr;
        logic              err;
        logic              irq_v;
        logic [3:0]        irq_c;
    } regs_t;

    regs_t d, q;

    logic          cond_pass;
    logic          stk_clr, stk_push, stk_pop;
    logic [AW-1:0] stk_top;
    logic          stk_full, stk_empty;
    logic [AW-1:0] ip_next, ip_skip;
    logic [DW-1:0] dec_val;
    logic [NFLAGS-1:0] fl_set, fl_clr;

    bcseq_cond #(.NFLAGS(NFLAGS)) u_cond (
        .code  (q.cond),
        .flags (q.flags),
        .pass  (cond_pass)
    );

    bcseq_stack #(.DEPTH(STACK_DEPTH), .W(AW)) u_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (stk_clr),
        .push      (stk_push),
        .pop       (stk_pop),
        .push_data (ip_next),
        .top_data  (stk_top),
        .full      (stk_full),
        .empty     (stk_empty)
    );

    always_comb begin
        d         = q;
        d.irq_v   = 1'b0;
        stk_clr   = 1'b0;
        stk_push  = 1'b0;
        stk_pop   = 1'b0;
        mem_rd_en = 1'b0;
        mem_wr_en = 1'b0;
        mem_addr  = q.ip;
        mem_wdata = '0;
        ip_next   = q.ip + AW'(2);
        ip_skip   = q.ip + AW'(4);
        dec_val   = mem_rdata - DW'(1);
        fl_set    = q.par[NFLAGS-1:0];
        fl_clr    = q.par[2*NFLAGS-1:NFLAGS];

        case (q.state)
            ST_IDLE, ST_HALT: begin
                if (start) begin
                    d.ip    = start_addr;
                    d.err   = 1'b0;
                    d.state = ST_FETCH;
                    stk_clr = 1'b1;
                end
            end
            ST_FETCH: begin
                mem_rd_en = 1'b1;
                mem_addr  = q.ip;
                d.state   = ST_OPW;
            end
            ST_OPW: begin
                d.opc     = mem_rdata[OPC_MSB:OPC_LSB];
                d.cond    = mem_rdata[COND_MSB:COND_LSB];
                mem_rd_en = 1'b1;
                mem_addr  = q.ip + AW'(1);
                d.state   = ST_PARW;
            end
            ST_PARW: begin
                d.par   = mem_rdata;
                d.state = ST_EXEC;
            end
            ST_EXEC: begin
                d.ip    = ip_next;
                d.state = ST_FETCH;
                if (cond_pass) begin
                    case (q.opc)
                        OP_EXEC, OP_XFLIP: begin
                            d.ip    = q.ip;
                            d.state = ST_MSG;
                        end
                        OP_JUMP: d.ip = q.par[AW-1:0];
                        OP_CALL: begin
                            if (stk_full) begin
                                d.ip    = q.ip;
                                d.err   = 1'b1;
                                d.state = ST_HALT;
                            end else begin
                                stk_push = 1'b1;
                                d.ip     = q.par[AW-1:0];
                            end
                        end
                        OP_RET: begin
                            if (stk_empty) begin
                                d.ip    = q.ip;
                                d.err   = 1'b1;
                                d.state = ST_HALT;
                            end else begin
                                stk_pop = 1'b1;
                                d.ip    = stk_top;
                            end
                        end
                        OP_IRQ: begin
                            d.irq_v = 1'b1;
                            d.irq_c = q.par[3:0];
                        end
                        OP_HALT: d.state = ST_HALT;
                        OP_FLAG: begin
                            d.flags = (q.flags & ~fl_set & ~fl_clr)
                                    | (fl_set & ~fl_clr)
                                    | (~q.flags & fl_set & fl_clr);
                        end
                        OP_SETWP: begin
                            if (q.par >= DW'(WPTR_MIN)) begin
                                d.wptr = q.par[AW-1:0];
                            end
                        end
                        OP_WIMM: begin
                            mem_wr_en = 1'b1;
                            mem_addr  = q.wptr;
                            mem_wdata = q.par;
                        end
                        OP_DSKIP: begin
                            d.ip    = q.ip;
                            d.state = ST_DSZR;
                        end
                        default: ;
                    endcase
                end
            end
            ST_MSG: begin
                if (msg_done) begin
                    d.flags[0] = msg_bad;
                    if (q.opc == OP_XFLIP) begin
                        d.state = ST_FLIP;
                    end else begin
                        d.ip    = ip_next;
                        d.state = ST_FETCH;
                    end
                end
            end
            ST_FLIP: begin
                mem_wr_en = 1'b1;
                mem_addr  = q.ip + AW'(1);
                mem_wdata = q.par ^ DW'(FLIP_MASK);
                d.ip      = ip_next;
                d.state   = ST_FETCH;
            end
            ST_DSZR: begin
                mem_rd_en = 1'b1;
                mem_addr  = q.par[AW-1:0];
                d.state   = ST_DSZW;
            end
            ST_DSZW: begin
                mem_wr_en = 1'b1;
                mem_addr  = q.par[AW-1:0];
                mem_wdata = dec_val;
                d.ip      = (dec_val == '0) ? ip_skip : ip_next;
                d.state   = ST_FETCH;
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_IDLE;
            q.wptr  <= AW'(WPTR_RESET);
        end else begin
            q <= d;
        end
    end

    assign msg_req   = (q.state == ST_MSG);
    assign msg_ptr   = q.par;
    assign irq_valid = q.irq_v;
    assign irq_code  = q.irq_c;
    assign busy      = (q.state != ST_IDLE) && (q.state != ST_HALT);
    assign halted    = (q.state == ST_HALT);
    assign stack_err = q.err;

    assert_first_fetch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (mem_rd_en && mem_addr == $past(start_addr)));
    assert_msg_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_req && !msg_done) |=> (msg_req && $stable(msg_ptr)));
    assert_err_halts_R6: assert property (@(posedge clk) disable iff (!rst_n)
        stack_err |-> halted);
    assert_wptr_floor_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_en && q.state == ST_EXEC) |-> (mem_addr >= AW'(WPTR_MIN)));
    assert_irq_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |=> !irq_valid);
    assert_halt_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!mem_wr_en && !msg_req && !busy));
endmodule

// File: tb/bcseq_top_tb.sv
module bcseq_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] start_addr = '0;
    logic        mem_rd_en, mem_wr_en;
    logic [15:0] mem_addr, mem_wdata;
    logic [15:0] mem_rdata = '0;
    logic        msg_req;
    logic [15:0] msg_ptr;
    logic        msg_done = 1'b0;
    logic        msg_bad = 1'b0;
    logic        irq_valid;
    logic [3:0]  irq_code;
    logic        busy, halted, stack_err;

    logic [15:0] bmem [0:1023];
    logic        h_we = 1'b0;
    logic [9:0]  h_addr = '0;
    logic [15:0] h_data = '0;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int msg_cnt = 0;
    int msg_log [0:15];
    int irq_cnt = 0;
    int irq_last = 0;

    always #10 clk = ~clk;

    bcseq_top u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .msg_req(msg_req), .msg_ptr(msg_ptr), .msg_done(msg_done), .msg_bad(msg_bad),
        .irq_valid(irq_valid), .irq_code(irq_code),
        .busy(busy), .halted(halted), .stack_err(stack_err)
    );

    always @(posedge clk) begin
        if (mem_wr_en) bmem[mem_addr[9:0]] <= mem_wdata;
        else if (h_we) bmem[h_addr] <= h_data;
        if (mem_rd_en) mem_rdata <= bmem[mem_addr[9:0]];
    end

    // message responder: done after 3 cycles, bad when pointer bit 9 is set
    initial begin
        forever begin
            @(negedge clk);
            if (msg_req) begin
                msg_log[msg_cnt % 16] = int'(msg_ptr);
                msg_cnt++;
                repeat (3) @(negedge clk);
                msg_bad  = msg_ptr[9];
                msg_done = 1'b1;
                @(negedge clk);
                msg_done = 1'b0;
            end
        end
    end

    always @(negedge clk) begin
        if (irq_valid) begin
            irq_cnt++;
            irq_last = int'(irq_code);
        end
    end

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                failures++;
                $display("FAIL watchdog actual=%0d expected=<150000", cyc);
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic poke(input int a, input int v);
        @(negedge clk);
        h_addr = a[9:0];
        h_data = v[15:0];
        h_we   = 1'b1;
        @(negedge clk);
        h_we   = 1'b0;
    endtask

    task automatic put(input int a, input int op, input int cnd, input int par);
        poke(a, ((cnd & 31) << 8) | (op & 31));
        poke(a + 1, par);
    endtask

    task automatic pulse_start(input int s);
        @(negedge clk);
        start_addr = s[15:0];
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run(input int s, input string req);
        int n;
        pulse_start(s);
        n = 0;
        while (!halted && n < 4000) begin
            @(negedge clk);
            n++;
        end
        if (!halted) chk(1'b0, {req, " run timeout"}, n, 4000);
    endtask

    function automatic bit cond_exp(input int c, input int p);
        if (c == 0) return 1'b1;
        if (c >= 8 && c < 16) return !p[c - 8];
        if (c >= 16 && c < 24) return p[c - 16];
        return 1'b0;
    endfunction

    initial begin
        int pats [0:3];
        int wv [0:5];
        pats = '{32'h00, 32'hFF, 32'hA5, 32'h3C};
        wv   = '{32'h0000, 32'h0001, 32'h004F, 32'h0050, 32'h0051, 32'h0170};
        for (int i = 0; i < 1024; i++) bmem[i] = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!busy && !halted && !stack_err, "R1 status", {busy, halted, stack_err}, 0);
        chk(!msg_req && !irq_valid && !mem_rd_en && !mem_wr_en, "R1 strobes",
            {msg_req, irq_valid, mem_rd_en, mem_wr_en}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!busy && !halted, "R1 idle after reset", {busy, halted}, 0);

        // R9 default write pointer, R2 start address
        put(16'h20, 5'h1C, 0, 16'h5A5A);
        put(16'h22, 5'h07, 0, 0);
        run(16'h20, "R2");
        chk(bmem[16'h50] == 16'h5A5A, "R9 default write pointer", bmem[16'h50], 16'h5A5A);
        chk(halted && !busy, "R11 halt state", {halted, busy}, 2);

        // R4 / R10 near-exhaustive condition sweep
        foreach (pats[pi]) begin
            for (int c = 0; c < 32; c++) begin
                poke(16'h100, 0);
                put(16'h10, 5'h1B, 0, 16'h0100);
                put(16'h12, 5'h0C, 0, 16'hFF00);
                put(16'h14, 5'h0C, 0, pats[pi]);
                put(16'h16, 5'h1C, c, 16'hAAAA);
                put(16'h18, 5'h07, 0, 0);
                run(16'h10, "R4");
                chk(bmem[16'h100] == (cond_exp(c, pats[pi]) ? 16'hAAAA : 16'h0000),
                    $sformatf("R4 cond=%0d flags=%0h", c, pats[pi]), bmem[16'h100],
                    cond_exp(c, pats[pi]) ? 16'hAAAA : 0);
            end
        end

        // R10 set, clear with bit 11, toggle
        for (int i = 0; i < 3; i++) poke(16'h110 + i, 0);
        put(16'h10, 5'h0C, 0, 16'hFF00);
        put(16'h12, 5'h0C, 0, 16'h0009);
        put(16'h14, 5'h0C, 0, 16'h0802);
        put(16'h16, 5'h0C, 0, 16'h0101);
        put(16'h18, 5'h1B, 0, 16'h0110);
        put(16'h1A, 5'h1C, 16, 1);
        put(16'h1C, 5'h1B, 0, 16'h0111);
        put(16'h1E, 5'h1C, 17, 1);
        put(16'h20, 5'h1B, 0, 16'h0112);
        put(16'h22, 5'h1C, 11, 1);
        put(16'h24, 5'h07, 0, 0);
        run(16'h10, "R10");
        chk(bmem[16'h110] == 0, "R10 toggle clears flag0", bmem[16'h110], 0);
        chk(bmem[16'h111] == 1, "R10 set flag1", bmem[16'h111], 1);
        chk(bmem[16'h112] == 1, "R10 bit11 clears flag3", bmem[16'h112], 1);

        // R5 execute result in flag 0
        for (int k = 0; k < 2; k++) begin
            int p;
            int m0;
            p = (k == 0) ? 16'h0040 : 16'h0240;
            poke(16'h120, 0);
            put(16'h10, 5'h1B, 0, 16'h0120);
            put(16'h12, 5'h01, 0, p);
            put(16'h14, 5'h1C, 16, 16'hBAD0);
            put(16'h16, 5'h07, 0, 0);
            m0 = msg_cnt;
            run(16'h10, "R5");
            chk(msg_cnt == m0 + 1 && msg_log[m0 % 16] == p, "R5 request pointer",
                msg_log[m0 % 16], p);
            chk(bmem[16'h120] == ((k == 1) ? 16'hBAD0 : 0), "R5 flag0 result",
                bmem[16'h120], (k == 1) ? 16'hBAD0 : 0);
        end

        // R2 start ignored while busy
        begin
            int m0;
            poke(16'h150, 0);
            put(16'h10, 5'h01, 0, 16'h0040);
            put(16'h12, 5'h07, 0, 0);
            put(16'h30, 5'h1B, 0, 16'h0150);
            put(16'h32, 5'h1C, 0, 16'h9999);
            put(16'h34, 5'h07, 0, 0);
            m0 = msg_cnt;
            pulse_start(16'h10);
            while (!msg_req) @(negedge clk);
            pulse_start(16'h30);
            while (!halted) @(negedge clk);
            chk(bmem[16'h150] == 0, "R2 start ignored while busy", bmem[16'h150], 0);
            chk(msg_cnt == m0 + 1, "R2 single message", msg_cnt - m0, 1);
        end

        // R8 decrement-and-skip loop counts
        for (int n = 1; n <= 5; n++) begin
            int m0;
            poke(16'h200, n);
            put(16'h10, 5'h01, 0, 16'h0040);
            put(16'h12, 5'h1D, 0, 16'h0200);
            put(16'h14, 5'h02, 0, 16'h0010);
            put(16'h16, 5'h07, 0, 0);
            m0 = msg_cnt;
            run(16'h10, "R8");
            chk(msg_cnt - m0 == n, $sformatf("R8 iterations n=%0d", n), msg_cnt - m0, n);
            chk(bmem[16'h200] == 0, "R8 counter decremented to zero", bmem[16'h200], 0);
        end

        // R6 nesting depth sweep, R3 jump/call absolute targets
        for (int dpt = 1; dpt <= 5; dpt++) begin
            int m0;
            put(16'h10, 5'h03, 0, 16'h0040);
            put(16'h12, 5'h07, 0, 0);
            for (int i = 0; i < dpt; i++) begin
                if (i < dpt - 1) begin
                    put(16'h40 + 8 * i, 5'h03, 0, 16'h40 + 8 * (i + 1));
                    put(16'h42 + 8 * i, 5'h01, 0, 16'h80 + 16'h20 * i);
                    put(16'h44 + 8 * i, 5'h04, 0, 0);
                end else begin
                    put(16'h40 + 8 * i, 5'h01, 0, 16'h80 + 16'h20 * i);
                    put(16'h42 + 8 * i, 5'h04, 0, 0);
                end
            end
            m0 = msg_cnt;
            run(16'h10, "R6");
            if (dpt <= 4) begin
                chk(!stack_err, $sformatf("R6 depth %0d no error", dpt), stack_err, 0);
                chk(msg_cnt - m0 == dpt, "R6 message count", msg_cnt - m0, dpt);
                for (int j = 0; j < dpt; j++)
                    chk(msg_log[(m0 + j) % 16] == 16'h80 + 16'h20 * (dpt - 1 - j),
                        "R3 call/return order", msg_log[(m0 + j) % 16],
                        16'h80 + 16'h20 * (dpt - 1 - j));
            end else begin
                chk(stack_err && halted, "R6 overflow halts", {stack_err, halted}, 3);
                chk(msg_cnt == m0, "R6 overflow no message", msg_cnt - m0, 0);
            end
        end
        put(16'h10, 5'h04, 0, 0);
        run(16'h10, "R6");
        chk(stack_err && halted, "R6 underflow halts", {stack_err, halted}, 3);
        put(16'h10, 5'h07, 0, 0);
        run(16'h10, "R2");
        chk(!stack_err, "R2 start clears stack error", stack_err, 0);

        // R7 execute-and-flip alternates
        put(16'h10, 5'h15, 0, 16'h0100);
        put(16'h12, 5'h07, 0, 0);
        for (int r = 0; r < 3; r++) begin
            int m0;
            int ep;
            ep = (r % 2 == 0) ? 16'h0100 : 16'h0110;
            m0 = msg_cnt;
            run(16'h10, "R7");
            chk(msg_log[m0 % 16] == ep, "R7 pointer used", msg_log[m0 % 16], ep);
            chk(bmem[16'h11] == (ep ^ 16'h10), "R7 own parameter flipped", bmem[16'h11],
                ep ^ 16'h10);
        end
        put(16'h10, 5'h15, 1, 16'h0100);
        begin
            int m0;
            m0 = msg_cnt;
            run(16'h10, "R7");
            chk(bmem[16'h11] == 16'h0100 && msg_cnt == m0, "R4 false flip has no effect",
                bmem[16'h11], 16'h0100);
        end

        // R9 write pointer floor sweep
        foreach (wv[wi]) begin
            int ea;
            ea = (wv[wi] >= 16'h50) ? wv[wi] : 16'h140;
            poke(16'h140, 0);
            if (wv[wi] >= 16'h50) poke(wv[wi], 0);
            put(16'h10, 5'h1B, 0, 16'h0140);
            put(16'h12, 5'h1B, 0, wv[wi]);
            put(16'h14, 5'h1C, 0, 16'h7777);
            put(16'h16, 5'h07, 0, 0);
            run(16'h10, "R9");
            chk(bmem[ea] == 16'h7777, $sformatf("R9 set pointer %0h", wv[wi]), bmem[ea], 16'h7777);
        end

        // R11 interrupt and halt, R3 unknown opcode no-op
        begin
            int i0;
            poke(16'h160, 0);
            poke(16'h161, 0);
            put(16'h10, 5'h1B, 0, 16'h0161);
            put(16'h12, 5'h1F, 0, 16'hFFFF);
            put(16'h14, 5'h1C, 0, 16'h0033);
            put(16'h16, 5'h06, 0, 16'h00FB);
            put(16'h18, 5'h07, 0, 0);
            put(16'h1A, 5'h1B, 0, 16'h0160);
            put(16'h1C, 5'h1C, 0, 16'h4444);
            i0 = irq_cnt;
            run(16'h10, "R11");
            repeat (4) @(negedge clk);
            chk(irq_cnt - i0 == 1 && irq_last == 4'hB, "R11 interrupt code", irq_last, 4'hB);
            chk(bmem[16'h161] == 16'h0033, "R3 unknown opcode skipped", bmem[16'h161], 16'h33);
            chk(bmem[16'h160] == 0 && halted && !busy, "R11 nothing after halt",
                bmem[16'h160], 0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule